// File: doc/BRIEF.md
# Dual-Tap Line-Scan Pixel Output Formatter

This block drives one sensor line at a time onto a parallel camera output. The output has two pixel buses, a data strobe and a line-valid flag. It runs on a core clock at four times the reference clock. It derives the reference clock itself and brings it out, so that the unit that drives the trigger can launch it on the reference falling edge. The trigger is sampled only on the reference rising edge. Several identical units that share the core clock and the trigger therefore start their lines in the same phase.

Two output formats are available. In two-tap mode an odd/even pixel pair leaves the block once per reference period. In single-tap mode one pixel leaves the block per half reference period, on the odd bus only. The pixel values come from an internal counter pattern, so any line can be predicted exactly. A line always lasts the same number of core cycles in both modes. The mode is fixed for each line when that line starts.

Top module: `dual_tap_line_out`

## Requirements
- R1: `ref_clk` is the core clock divided by four. It is high for two core cycles and low for two, and it starts high when the internal reset is released.
- R2: A line starts only when `trig` is sampled high at a reference rising edge after being sampled low at the previous one. `lval` then rises on the first core clock edge after that reference rising edge.
- R3: Holding `trig` high starts exactly one line. While `trig` stays at one level, no line is started.
- R4: A low-to-high trigger sample taken while a line is being output is ignored, including a sample at the last core cycle of the line. No line follows from it.
- R5: `lval` stays high for exactly 2*LINE_LEN core cycles per line and is low for at least one core cycle between lines.
- R6: With `tap_sel`=0 (two-tap), pixels are numbered from 1. Pair k, counted from 0, holds pixel 2k+1 on `odd_px` and pixel 2k+2 on `even_px` for four core cycles. The value of pixel n is the low PIX_W bits of n XOR PAT_XOR (default 0x5A3). Bit 0 is the LSB.
- R7: With `tap_sel`=1 (single-tap), pixels 1..LINE_LEN appear in order on `odd_px`, two core cycles each, with the same value rule as R6. `even_px` is 0 throughout the line.
- R8: In two-tap mode `strobe` is low for the first two core cycles of each pair and high for the last two. In single-tap mode it is low for the first core cycle of each pixel and high for the second. The buses never change on a cycle where `strobe` rises. While `lval` is low, `strobe`, `odd_px` and `even_px` are all 0.
- R9: `tap_sel` is taken at the reference rising edge that starts a line. Changing it during the line has no effect on that line.
- R10: `rst_n` low clears `lval`, `strobe` and both buses at once and aborts any line. Its release passes through SYNC_STAGES flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, four times the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Line trigger, launched on the reference falling edge |
| tap_sel | input | 1 | 0 = two taps at reference rate, 1 = one tap at twice the rate |
| ref_clk | output | 1 | Reference clock derived from the core clock |
| odd_px | output | PIX_W | Odd pixel bus, or the only bus in single-tap mode |
| even_px | output | PIX_W | Even pixel bus, zero in single-tap mode |
| strobe | output | 1 | Data strobe; the buses are valid on its rising edge |
| lval | output | 1 | Line valid, high while a line is output |

## Verification
The bench drives lines in both tap modes, with single-period and multi-period trigger pulses, and with random idle gaps between them. A cycle-by-cycle model separates a wrong pixel order, a wrong bus assignment or a wrong strobe phase from timing errors. Some stimulus adds extra trigger pulses during a line, sometimes together with a `tap_sel` flip. This separates a correct ignore-and-latch design from one that restarts the line or switches format partway through. A trigger held high for several line lengths and a reset in the middle of a line check the single-start rule and the asynchronous clear.

// File: rtl/dtl_pkg.sv
`timescale 1ns/1ps
package dtl_pkg;
  typedef enum logic {
    TAP_DUAL   = 1'b0,
    TAP_SINGLE = 1'b1
  } tap_mode_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/dtl_rst_sync.sv
`timescale 1ns/1ps
module dtl_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [SYNC_STAGES-1:0] stg_q;
  logic [SYNC_STAGES-1:0] stg_nxt;

  always_comb begin
    stg_nxt = {stg_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_nxt;
  end

  assign rst_n_sync = stg_q[SYNC_STAGES-1];
endmodule

// File: rtl/dtl_phase_gen.sv
`timescale 1ns/1ps
module dtl_phase_gen #(
  parameter int PH_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_clk,
  output logic samp_en
);
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_nxt;

  always_comb begin
    ph_nxt = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_nxt;
  end

  // reference is high in the first half of the phase count
  assign ref_clk = ~ph_q[PH_W-1];
  // last phase: the coming edge is the reference rising edge
  assign samp_en = &ph_q;
endmodule

// File: rtl/dtl_trig_sample.sv
`timescale 1ns/1ps
module dtl_trig_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_en,
  input  logic trig,
  output logic trig_rise
);
  logic trig_q;
  logic trig_nxt;

  always_comb begin
    trig_nxt = trig_q;
    if (samp_en) trig_nxt = trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_nxt;
  end

  // only meaningful at the sampling edge; trig was launched half a period earlier
  assign trig_rise = samp_en & trig & ~trig_q;
endmodule

// File: rtl/dtl_line_seq.sv
`timescale 1ns/1ps
module dtl_line_seq
  import dtl_pkg::*;
#(
  parameter int LINE_LEN = 64,
  parameter int C_W      = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trig_rise,
  input  logic           tap_sel,
  output logic           run,
  output logic [C_W-1:0] cnt,
  output tap_mode_e      mode
);
  localparam logic [C_W-1:0] LAST = C_W'(2*LINE_LEN-1);

  seq_state_e     st_q, st_nxt;
  logic [C_W-1:0] cnt_q, cnt_nxt;
  tap_mode_e      mode_q, mode_nxt;

  always_comb begin
    st_nxt   = st_q;
    cnt_nxt  = cnt_q;
    mode_nxt = mode_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (trig_rise) begin
          st_nxt   = SEQ_RUN;
          cnt_nxt  = '0;
          mode_nxt = tap_mode_e'(tap_sel);
        end
      end
      SEQ_RUN: begin
        if (cnt_q == LAST) begin
          st_nxt  = SEQ_IDLE;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = cnt_q + C_W'(1);
        end
      end
      default: st_nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      mode_q <= TAP_DUAL;
    end else begin
      st_q   <= st_nxt;
      cnt_q  <= cnt_nxt;
      mode_q <= mode_nxt;
    end
  end

  assign run  = (st_q == SEQ_RUN);
  assign cnt  = cnt_q;
  assign mode = mode_q;
endmodule

// File: rtl/dtl_formatter.sv
`timescale 1ns/1ps
module dtl_formatter
  import dtl_pkg::*;
#(
  parameter int          PIX_W   = 12,
  parameter int          C_W     = 7,
  parameter int unsigned PAT_XOR = 'h5A3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [C_W-1:0]   cnt,
  input  tap_mode_e        mode,
  output logic [PIX_W-1:0] odd_px,
  output logic [PIX_W-1:0] even_px,
  output logic             strobe,
  output logic             lval
);
  localparam int              N_TAPS = 2;
  localparam logic [PIX_W-1:0] XMASK = PIX_W'(PAT_XOR);

  function automatic logic [PIX_W-1:0] pix_of(input logic [C_W-1:0] n);
    return PIX_W'(n) ^ XMASK;
  endfunction

  logic [C_W-1:0] n_half;
  logic [C_W-1:0] n_pair_lead;
  logic [C_W-1:0] n_single;
  logic [PIX_W-1:0] tap_bus [N_TAPS];

  always_comb begin
    n_half      = cnt >> 1;
    n_pair_lead = n_half | C_W'(1);
    n_single    = n_half + C_W'(1);
  end

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    logic [PIX_W-1:0] v_nxt;
    logic [PIX_W-1:0] v_q;

    if (t == 0) begin : g_lead
      always_comb begin
        v_nxt = '0;
        if (run) begin
          if (mode == TAP_DUAL) v_nxt = pix_of(n_pair_lead);
          else                  v_nxt = pix_of(n_single);
        end
      end
    end else begin : g_trail
      always_comb begin
        v_nxt = '0;
        if (run && mode == TAP_DUAL) v_nxt = pix_of(n_pair_lead + C_W'(t));
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= '0;
      else        v_q <= v_nxt;
    end

    assign tap_bus[t] = v_q;
  end

  logic strobe_nxt, strobe_q;
  logic lval_nxt, lval_q;

  always_comb begin
    lval_nxt   = run;
    strobe_nxt = 1'b0;
    if (run) strobe_nxt = (mode == TAP_DUAL) ? cnt[1] : cnt[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      lval_q   <= 1'b0;
    end else begin
      strobe_q <= strobe_nxt;
      lval_q   <= lval_nxt;
    end
  end

  assign odd_px  = tap_bus[0];
  assign even_px = tap_bus[1];
  assign strobe  = strobe_q;
  assign lval    = lval_q;
endmodule

// File: rtl/dual_tap_line_out.sv
`timescale 1ns/1ps
module dual_tap_line_out
  import dtl_pkg::*;
#(
  parameter int          LINE_LEN    = 64,
  parameter int          PIX_W       = 12,
  parameter int unsigned PAT_XOR     = 'h5A3,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             tap_sel,
  output logic             ref_clk,
  output logic [PIX_W-1:0] odd_px,
  output logic [PIX_W-1:0] even_px,
  output logic             strobe,
  output logic             lval
);
  // core clock runs at four times the reference clock
  localparam int PH_W = 2;
  localparam int C_W  = $clog2(2*LINE_LEN);

  logic           rst_n_int;
  logic           samp_en;
  logic           trig_rise;
  logic           run;
  logic [C_W-1:0] cnt;
  tap_mode_e      line_mode;

  dtl_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  dtl_phase_gen #(.PH_W(PH_W)) i_phase (
    .clk(clk), .rst_n(rst_n_int), .ref_clk(ref_clk), .samp_en(samp_en)
  );

  dtl_trig_sample i_trig (
    .clk(clk), .rst_n(rst_n_int), .samp_en(samp_en), .trig(trig),
    .trig_rise(trig_rise)
  );

  dtl_line_seq #(.LINE_LEN(LINE_LEN), .C_W(C_W)) i_seq (
    .clk(clk), .rst_n(rst_n_int), .trig_rise(trig_rise), .tap_sel(tap_sel),
    .run(run), .cnt(cnt), .mode(line_mode)
  );

  dtl_formatter #(.PIX_W(PIX_W), .C_W(C_W), .PAT_XOR(PAT_XOR)) i_fmt (
    .clk(clk), .rst_n(rst_n_int), .run(run), .cnt(cnt), .mode(line_mode),
    .odd_px(odd_px), .even_px(even_px), .strobe(strobe), .lval(lval)
  );
endmodule

// File: rtl/dual_tap_line_out_chk.sv
`timescale 1ns/1ps
module dual_tap_line_out_chk #(
  parameter int LINE_LEN = 64,
  parameter int PIX_W    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_clk,
  input logic             lval,
  input logic             strobe,
  input logic [PIX_W-1:0] odd_px,
  input logic [PIX_W-1:0] even_px,
  input logic             line_mode
);
  logic [31:0] hi_cnt;
  logic        lval_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lval_d <= 1'b0;
    end else begin
      hi_cnt <= lval ? hi_cnt + 32'd1 : 32'd0;
      lval_d <= lval;
    end
  end

  // R1
  ref_high_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_clk) |=> ref_clk ##1 !ref_clk);

  // R1
  ref_low_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_clk) |=> !ref_clk ##1 ref_clk);

  // R2
  start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lval) |-> ref_clk && $past(ref_clk) && !$past(ref_clk, 2));

  // R5
  line_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lval_d && !lval) |-> hi_cnt == 32'(2*LINE_LEN));

  // R5
  line_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lval) |=> !lval);

  // R7
  single_even_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lval && line_mode) |-> even_px == '0);

  // R8
  strobe_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $stable(odd_px) && $stable(even_px));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lval |-> !strobe && odd_px == '0 && even_px == '0);
endmodule

bind dual_tap_line_out dual_tap_line_out_chk #(
  .LINE_LEN(LINE_LEN), .PIX_W(PIX_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .lval(lval), .strobe(strobe),
  .odd_px(odd_px), .even_px(even_px), .line_mode(line_mode)
);

// File: tb/test_dual_tap_line_out.sv
`timescale 1ns/1ps
module test_dual_tap_line_out;
  localparam int          CLK_PERIOD = 10;
  localparam int          LINE_LEN   = 64;
  localparam int          PIX_W      = 12;
  localparam int unsigned PAT_XOR    = 'h5A3;
  localparam int          WD_CYCLES  = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             trig = 1'b0;
  logic             tap_sel = 1'b0;
  logic             ref_clk;
  logic [PIX_W-1:0] odd_px, even_px;
  logic             strobe, lval;

  int n_chk = 0;
  int n_bad = 0;
  int rises = 0;

  dual_tap_line_out #(.LINE_LEN(LINE_LEN), .PIX_W(PIX_W), .PAT_XOR(PAT_XOR)) i_dual_tap_line_out (
    .clk(clk), .rst_n(rst_n), .trig(trig), .tap_sel(tap_sel), .ref_clk(ref_clk),
    .odd_px(odd_px), .even_px(even_px), .strobe(strobe), .lval(lval)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [PIX_W-1:0] exp_pix(input int n);
    return PIX_W'(n) ^ PIX_W'(PAT_XOR);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // phase tracking from the observed reference clock
  bit       locked = 0;
  int       bph = 0;
  logic     prev_ref = 1'b1;
  logic     prev_lval = 1'b0;

  // model of the design, advanced at each rising edge
  bit               m_act = 0;
  int               m_c = 0;
  logic             m_mode = 1'b0;
  logic             m_trs = 1'b0;
  logic             e_lval = 1'b0, e_str = 1'b0;
  logic [PIX_W-1:0] e_odd = '0, e_even = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_c = 0; m_mode = 1'b0; m_trs = 1'b0;
      e_lval = 1'b0; e_str = 1'b0; e_odd = '0; e_even = '0;
    end else begin
      e_lval = m_act;
      if (!m_act) begin
        e_str = 1'b0; e_odd = '0; e_even = '0;
      end else if (m_mode == 1'b0) begin
        e_odd  = exp_pix(2*(m_c/4) + 1);
        e_even = exp_pix(2*(m_c/4) + 2);
        e_str  = (m_c % 4) >= 2;
      end else begin
        e_odd  = exp_pix(m_c/2 + 1);
        e_even = '0;
        e_str  = (m_c % 2) == 1;
      end
      if (m_act) begin
        if (m_c == 2*LINE_LEN-1) m_act = 0;
        else m_c++;
      end else if (locked && bph == 3 && trig && !m_trs) begin
        m_act = 1; m_c = 0; m_mode = tap_sel;
      end
      if (locked && bph == 3) m_trs = trig;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      locked = 0;
      prev_ref = ref_clk;
      chk("R10 lval in reset", 32'(lval), 32'd0);
      chk("R10 strobe in reset", 32'(strobe), 32'd0);
      chk("R10 odd_px in reset", 32'(odd_px), 32'd0);
      chk("R10 even_px in reset", 32'(even_px), 32'd0);
    end else begin
      if (!locked) begin
        if (ref_clk && !prev_ref) begin locked = 1; bph = 0; end
      end else begin
        bph = (bph + 1) % 4;
      end
      prev_ref = ref_clk;
      if (locked) begin
        chk("R1 ref_clk shape", 32'(ref_clk), 32'(bph < 2));
        chk("R2 R5 lval timing", 32'(lval), 32'(e_lval));
        chk("R8 strobe phase", 32'(strobe), 32'(e_str));
        chk("R6 R7 R9 odd_px", 32'(odd_px), 32'(e_odd));
        chk("R6 R7 R9 even_px", 32'(even_px), 32'(e_even));
        if (lval && !prev_lval) rises++;
      end
    end
    prev_lval = lval;
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_ref_fall();
    logic r0;
    do begin
      r0 = ref_clk;
      @(negedge clk);
    end while (!(r0 && !ref_clk));
    #1;
  endtask

  task automatic pulse_trig(input int periods);
    wait_ref_fall();
    trig = 1'b1;
    repeat (periods) wait_ref_fall();
    trig = 1'b0;
  endtask

  task automatic wait_line_done();
    while (lval) @(negedge clk);
    #1;
  endtask

  task automatic wait_lock();
    while (!locked) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int r0;
    void'($urandom(32'h1D5E_2A71));
    wait_cycles(6);
    rst_n = 1'b1;
    wait_lock();
    wait_cycles(8);

    // R6 one two-tap line
    r0 = rises;
    tap_sel = 1'b0;
    pulse_trig(1);
    wait_line_done();
    wait_cycles(4);
    chk("R2 one line per pulse (two-tap)", 32'(rises - r0), 32'd1);

    // R7 one single-tap line
    r0 = rises;
    tap_sel = 1'b1;
    pulse_trig(2);
    wait_line_done();
    wait_cycles(4);
    chk("R7 one line per pulse (single-tap)", 32'(rises - r0), 32'd1);

    // R3 trigger held high across several line lengths
    r0 = rises;
    tap_sel = 1'b0;
    wait_ref_fall();
    trig = 1'b1;
    wait_cycles(3*2*LINE_LEN + 40);
    wait_ref_fall();
    trig = 1'b0;
    wait_cycles(200);
    chk("R3 held trigger starts one line", 32'(rises - r0), 32'd1);
    chk("R3 no line without new edge", 32'(lval), 32'd0);

    // R4 R9 trigger and mode flip in the middle of a line
    r0 = rises;
    tap_sel = 1'b1;
    pulse_trig(1);
    wait_cycles(20);
    tap_sel = 1'b0;
    pulse_trig(1);
    wait_line_done();
    wait_cycles(60);
    chk("R4 trigger during line ignored", 32'(rises - r0), 32'd1);

    // back-to-back: trigger at first reference fall after a line
    r0 = rises;
    pulse_trig(1);
    wait_line_done();
    pulse_trig(1);
    wait_line_done();
    wait_cycles(8);
    chk("R5 back-to-back lines", 32'(rises - r0), 32'd2);

    // R10 reset in the middle of a line
    tap_sel = 1'b0;
    pulse_trig(1);
    wait_cycles(30);
    rst_n = 1'b0;
    #1;
    chk("R10 async clear lval", 32'(lval), 32'd0);
    chk("R10 async clear strobe", 32'(strobe), 32'd0);
    chk("R10 async clear odd_px", 32'(odd_px), 32'd0);
    wait_cycles(4);
    rst_n = 1'b1;
    wait_lock();
    wait_cycles(4);

    // constrained random lines
    for (int i = 0; i < 24; i++) begin
      tap_sel = 1'($urandom % 2);
      wait_cycles($urandom % 13);
      pulse_trig(1 + ($urandom % 3));
      if (($urandom % 2) == 1) begin
        wait_cycles($urandom % 60);
        tap_sel = ~tap_sel;
        pulse_trig(1);
      end
      if (($urandom % 4) != 0) wait_line_done();
    end
    wait_line_done();
    wait_cycles(20);
    finish_run();
  end
endmodule